// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block takes one interrupt routing request (a destination byte, an addressing-mode flag, a delivery mode and a vector) and works out which of up to `NUM_SLOTS` processor slots it targets. Each slot is described on the inputs by a present flag, a physical identifier and a logical identifier. The matching slots form a target bitmask. That bitmask is then turned into a sequence of single-cycle delivery pulses, one per target and one target per cycle, each tagged with the slot index and either the vector or an NMI indication.

A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. The slot tables and request fields are sampled only on that edge. The block then walks the captured bitmask. For fixed mode it emits one vector pulse per target. For lowest-priority mode it emits a single vector pulse. For NMI mode it emits one NMI pulse per target. It closes every request with a one-cycle completion strobe that says whether the request found no target or used an unsupported delivery mode.

Top module: `irq_dest_resolver`

## Requirements
- R1: With `reqLogical`=0 (physical addressing) and `reqDest` all ones (0xFF), every slot whose present flag is set is a target.
- R2: With `reqLogical`=0 and any other `reqDest`, the targets are exactly the present slots whose physical ID equals `reqDest`. Absent slots never match.
- R3: With `reqLogical`=1 (logical addressing) and `reqDest`=0, no slot is a target.
- R4: With `reqLogical`=1 and a nonzero `reqDest`, the targets are the present slots whose logical ID has at least one bit in common with `reqDest`.
- R5: When the target set is empty, no delivery pulse is produced. The completion strobe `doneValid` then comes with `doneFail`=1.
- R6: In fixed mode (`reqMode`=3'd0), targets receive `dlvValid` pulses in ascending slot index order, one per cycle. Each pulse carries the slot in `dlvTarget` and the captured vector in `dlvVector`.
- R7: In lowest-priority mode (`reqMode`=3'd1), exactly one `dlvValid` pulse is produced, and it goes to the lowest-indexed target.
- R8: In NMI mode (`reqMode`=3'd4), every target receives an `nmiValid` pulse, in ascending index order with the index on `dlvTarget`, and no `dlvValid` pulse occurs.
- R9: Any other `reqMode` value produces no pulse. It is completed with `doneUnsupported`=1 and `doneFail`=1.
- R10: The first pulse appears in the cycle right after acceptance. `doneValid` appears in the cycle right after the last pulse, or right after acceptance if there are no pulses. `reqReady` is low from acceptance until the completion cycle has passed.
- R11: After reset, `reqReady` is 1 and `dlvValid`, `nmiValid` and `doneValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request can be taken |
| reqDest | input | ID_W | Destination byte |
| reqLogical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| reqMode | input | 3 | Delivery mode: 0 fixed, 1 lowest priority, 4 NMI |
| reqVector | input | VEC_W | Interrupt vector |
| slotPresent | input | NUM_SLOTS | Present flag per slot |
| slotPhysId | input | NUM_SLOTS*ID_W | Physical IDs, slot i at bits [i*ID_W +: ID_W] |
| slotLogId | input | NUM_SLOTS*ID_W | Logical IDs, same packing |
| dlvValid | output | 1 | Vector delivery pulse |
| nmiValid | output | 1 | NMI delivery pulse |
| dlvTarget | output | $clog2(NUM_SLOTS) | Slot index of the current pulse |
| dlvVector | output | VEC_W | Vector of the current request |
| doneValid | output | 1 | Request completion strobe |
| doneFail | output | 1 | Completed request had no target |
| doneUnsupported | output | 1 | Completed request had an unsupported mode |

## Verification
Random slot tables are built with physical IDs drawn from a small range, so that several slots often share an ID and single, multiple and zero physical matches all occur. Sparse logical IDs test the AND rule against an equality rule. Directed cases cover the following:
- broadcast with gaps in the present flags, which tells "all present" apart from "all slots";
- an absent slot that carries a matching ID;
- a logical destination of zero against slots with full logical IDs;
- a lowest-priority request whose only targets sit at higher indices, which tells "lowest set bit" apart from "slot 0".

Every pulse is checked in its exact cycle, so the tests also catch reordering, skipped targets and off-by-one timing.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam logic [2:0] MODE_FIXED  = 3'd0;
  localparam logic [2:0] MODE_LOWEST = 3'd1;
  localparam logic [2:0] MODE_NMI    = 3'd4;

  typedef struct packed {
    logic load;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/irq_dest_datapath.sv
module irq_dest_datapath
  import irq_dest_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 8,
  parameter int VEC_W     = 8,
  localparam int TGT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [ID_W-1:0]           reqDest,
  input  logic                      reqLogical,
  input  logic [2:0]                reqMode,
  input  logic [VEC_W-1:0]          reqVector,
  input  logic [NUM_SLOTS-1:0]      slotPresent,
  input  logic [NUM_SLOTS*ID_W-1:0] slotPhysId,
  input  logic [NUM_SLOTS*ID_W-1:0] slotLogId,
  output logic                      maskEmpty,
  output logic [TGT_W-1:0]          pickIdx,
  output logic [VEC_W-1:0]          vecQ,
  output logic                      nmiQ,
  output logic                      failQ,
  output logic                      unsupQ
);
  localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

  logic [NUM_SLOTS-1:0] rawMask;
  logic [NUM_SLOTS-1:0] lowBit;
  logic [NUM_SLOTS-1:0] loadMask;
  logic [NUM_SLOTS-1:0] maskQ;
  logic                 modeUnsupported;

  // Per-slot address match
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gMatch
    logic [ID_W-1:0] physId;
    logic [ID_W-1:0] logId;
    logic            physHit;
    logic            logHit;
    assign physId  = slotPhysId[g*ID_W +: ID_W];
    assign logId   = slotLogId[g*ID_W +: ID_W];
    assign physHit = (reqDest == BCAST) || (physId == reqDest);
    assign logHit  = (reqDest != '0) && ((reqDest & logId) != '0);
    assign rawMask[g] = slotPresent[g] && (reqLogical ? logHit : physHit);
  end

  assign modeUnsupported = !(reqMode == MODE_FIXED || reqMode == MODE_LOWEST ||
                             reqMode == MODE_NMI);
  assign lowBit = rawMask & (~rawMask + NUM_SLOTS'(1));

  always_comb begin
    if (modeUnsupported)             loadMask = '0;
    else if (reqMode == MODE_LOWEST) loadMask = lowBit;
    else                             loadMask = rawMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      vecQ   <= '0;
      nmiQ   <= 1'b0;
      failQ  <= 1'b0;
      unsupQ <= 1'b0;
    end else if (strobe.load) begin
      maskQ  <= loadMask;
      vecQ   <= reqVector;
      nmiQ   <= (reqMode == MODE_NMI);
      failQ  <= (loadMask == '0);
      unsupQ <= modeUnsupported;
    end else if (strobe.advance) begin
      maskQ  <= maskQ & (maskQ - NUM_SLOTS'(1));
    end
  end

  assign maskEmpty = (maskQ == '0);

  always_comb begin
    logic found;
    found   = 1'b0;
    pickIdx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (maskQ[i] && !found) begin
        pickIdx = TGT_W'(i);
        found   = 1'b1;
      end
    end
  end

  // R6: each delivery retires exactly one target
  assert_advance_drops_one_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ($countones(maskQ) == $past($countones(maskQ)) - 1));

  // R7: lowest-priority leaves at most one target
  assert_lowest_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqMode == MODE_LOWEST) |=> ($countones(maskQ) <= 1));

  // R9: unsupported mode captures no target
  assert_unsup_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && modeUnsupported) |=> (maskEmpty && unsupQ && failQ));
endmodule

// File: rtl/irq_dest_control.sv
module irq_dest_control
  import irq_dest_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      maskEmpty,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      pulseActive,
  output logic      doneActive
);
  typedef enum logic {ST_IDLE, ST_WALK} state_e;
  state_e state;

  assign reqReady       = (state == ST_IDLE);
  assign pulseActive    = (state == ST_WALK) && !maskEmpty;
  assign doneActive     = (state == ST_WALK) && maskEmpty;
  assign strobe.load    = reqReady && reqValid;
  assign strobe.advance = pulseActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              state <= ST_IDLE;
    else if (strobe.load)   state <= ST_WALK;
    else if (doneActive)    state <= ST_IDLE;
  end

  // R10: completion returns the block to idle on the next cycle
  assert_done_to_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneActive |=> reqReady);

  // R10: acceptance leaves idle
  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !reqReady);
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 8,
  parameter int VEC_W     = 8,
  localparam int TGT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ID_W-1:0]           reqDest,
  input  logic                      reqLogical,
  input  logic [2:0]                reqMode,
  input  logic [VEC_W-1:0]          reqVector,
  input  logic [NUM_SLOTS-1:0]      slotPresent,
  input  logic [NUM_SLOTS*ID_W-1:0] slotPhysId,
  input  logic [NUM_SLOTS*ID_W-1:0] slotLogId,
  output logic                      dlvValid,
  output logic                      nmiValid,
  output logic [TGT_W-1:0]          dlvTarget,
  output logic [VEC_W-1:0]          dlvVector,
  output logic                      doneValid,
  output logic                      doneFail,
  output logic                      doneUnsupported
);
  dpStrobe_t strobe;
  logic      maskEmpty;
  logic      pulseActive;
  logic      nmiQ;

  irq_dest_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .maskEmpty  (maskEmpty),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .pulseActive(pulseActive),
    .doneActive (doneValid)
  );

  irq_dest_datapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .ID_W     (ID_W),
    .VEC_W    (VEC_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqDest    (reqDest),
    .reqLogical (reqLogical),
    .reqMode    (reqMode),
    .reqVector  (reqVector),
    .slotPresent(slotPresent),
    .slotPhysId (slotPhysId),
    .slotLogId  (slotLogId),
    .maskEmpty  (maskEmpty),
    .pickIdx    (dlvTarget),
    .vecQ       (dlvVector),
    .nmiQ       (nmiQ),
    .failQ      (doneFail),
    .unsupQ     (doneUnsupported)
  );

  assign dlvValid = pulseActive && !nmiQ;
  assign nmiValid = pulseActive && nmiQ;

  // R8: a cycle carries at most one kind of event
  assert_one_event_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dlvValid, nmiValid, doneValid}));

  // R5: a failed request never produced a pulse since its acceptance
  assert_fail_no_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFail) |-> $past(reqReady));
endmodule

// File: tb/test_irq_dest_resolver.sv
module test_irq_dest_resolver;
  localparam int N = 8;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           reqValid = 1'b0;
  logic           reqReady;
  logic [W-1:0]   reqDest = '0;
  logic           reqLogical = 1'b0;
  logic [2:0]     reqMode = '0;
  logic [W-1:0]   reqVector = '0;
  logic [N-1:0]   slotPresent = '0;
  logic [N*W-1:0] slotPhysId = '0;
  logic [N*W-1:0] slotLogId = '0;
  logic           dlvValid, nmiValid, doneValid, doneFail, doneUnsupported;
  logic [2:0]     dlvTarget;
  logic [W-1:0]   dlvVector;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  irq_dest_resolver i_irq_dest_resolver (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqDest(reqDest), .reqLogical(reqLogical), .reqMode(reqMode),
    .reqVector(reqVector), .slotPresent(slotPresent), .slotPhysId(slotPhysId),
    .slotLogId(slotLogId), .dlvValid(dlvValid), .nmiValid(nmiValid),
    .dlvTarget(dlvTarget), .dlvVector(dlvVector), .doneValid(doneValid),
    .doneFail(doneFail), .doneUnsupported(doneUnsupported)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog act=%0d exp=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] refMask(input logic [W-1:0] d, input logic lg);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] p = slotPhysId[i*W +: W];
      logic [W-1:0] l = slotLogId[i*W +: W];
      if (slotPresent[i]) begin
        if (!lg) m[i] = (d == 8'hFF) || (p == d);
        else     m[i] = (d != 0) && ((d & l) != 0);
      end
    end
    return m;
  endfunction

  task automatic runReq(input logic [W-1:0] d, input logic lg, input logic [2:0] md,
                        input logic [W-1:0] v);
    logic [N-1:0] m;
    logic         unsup;
    string        tagA, tagP;
    int           n, got;
    @(negedge clk);
    check(reqReady === 1'b1, "R10", "ready before request", 32'(reqReady), 1);
    m = refMask(d, lg);
    unsup = !(md == 3'd0 || md == 3'd1 || md == 3'd4);
    if (unsup) m = '0;
    else if (md == 3'd1) m = m & (~m + 8'd1);
    n = $countones(m);
    tagA = lg ? ((d == 0) ? "R3" : "R4") : ((d == 8'hFF) ? "R1" : "R2");
    tagP = (md == 3'd4) ? "R8" : ((md == 3'd1) ? "R7" : "R6");
    reqDest = d; reqLogical = lg; reqMode = md; reqVector = v; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    got = 0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        check((md == 3'd4) ? (nmiValid === 1'b1 && dlvValid === 1'b0)
                           : (dlvValid === 1'b1 && nmiValid === 1'b0),
              tagP, "pulse kind", {30'd0, dlvValid, nmiValid}, (md == 3'd4) ? 1 : 2);
        check(dlvTarget === 3'(i), tagP, "target order", 32'(dlvTarget), i);
        if (md != 3'd4)
          check(dlvVector === v, "R6", "vector tag", 32'(dlvVector), 32'(v));
        check(reqReady === 1'b0 && doneValid === 1'b0, "R10", "busy during walk",
              {30'd0, reqReady, doneValid}, 0);
        if (dlvValid || nmiValid) got++;
        @(negedge clk);
      end
    end
    check(got == n, tagA, "target count", got, n);
    check(doneValid === 1'b1 && dlvValid === 1'b0 && nmiValid === 1'b0, "R10",
          "done timing", {29'd0, doneValid, dlvValid, nmiValid}, 4);
    check(doneFail === (n == 0), unsup ? "R9" : "R5", "done fail",
          32'(doneFail), 32'(n == 0));
    check(doneUnsupported === unsup, "R9", "done unsupported",
          32'(doneUnsupported), 32'(unsup));
  endtask

  task automatic setSlot(input int i, input logic pr, input logic [W-1:0] p,
                         input logic [W-1:0] l);
    slotPresent[i] = pr;
    slotPhysId[i*W +: W] = p;
    slotLogId[i*W +: W] = l;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1, "R11", "reset ready", 32'(reqReady), 1);
    check({dlvValid, nmiValid, doneValid} === 3'b000, "R11", "reset outputs",
          {29'd0, dlvValid, nmiValid, doneValid}, 0);

    // Directed corner cases
    for (int i = 0; i < N; i++) setSlot(i, (i % 3) != 1, W'(i + 1), W'(1 << i));
    runReq(8'hFF, 1'b0, 3'd0, 8'h31);   // R1 broadcast, gaps in present
    runReq(8'h03, 1'b0, 3'd0, 8'h32);   // R2 single match
    runReq(8'h02, 1'b0, 3'd0, 8'h33);   // R2 absent slot carries the ID
    runReq(8'h40, 1'b0, 3'd0, 8'h34);   // R5 no physical match
    for (int i = 0; i < N; i++) setSlot(i, 1'b1, W'(i), 8'hFF);
    runReq(8'h00, 1'b1, 3'd0, 8'h35);   // R3 logical zero
    for (int i = 0; i < N; i++) setSlot(i, 1'b1, W'(i), W'(1 << (i % 4)));
    runReq(8'h0A, 1'b1, 3'd4, 8'h36);   // R4 + R8
    slotPresent = 8'b1111_0000;
    runReq(8'hFF, 1'b0, 3'd1, 8'h37);   // R7 lowest bit is slot 4
    runReq(8'hFF, 1'b0, 3'd2, 8'h38);   // R9 unsupported
    runReq(8'hFF, 1'b0, 3'd7, 8'h39);   // R9 unsupported

    // Constrained random
    for (int t = 0; t < 400; t++) begin
      logic [W-1:0] d;
      logic         lg;
      logic [2:0]   md;
      for (int i = 0; i < N; i++)
        setSlot(i, ($urandom % 4) != 0, W'($urandom % 6),
                W'((1 << ($urandom % 8)) | (($urandom % 2) << ($urandom % 8))));
      lg = 1'($urandom % 2);
      case ($urandom % 8)
        0:       d = lg ? 8'h00 : 8'hFF;
        1:       d = 8'hFF;
        default: d = lg ? W'($urandom) : W'($urandom % 7);
      endcase
      case ($urandom % 7)
        0, 1:    md = 3'd0;
        2, 3:    md = 3'd1;
        4, 5:    md = 3'd4;
        default: md = 3'($urandom);
      endcase
      runReq(d, lg, md, W'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule